// File: doc/BRIEF.md
# Prefix-Segmented Longest-Match Table Updater

This block keeps a ternary match table in the order that longest-prefix lookup needs. The table has one contiguous segment for each IPv4 prefix length from 32 down to 0. Segment index is `32 - length`, so the longest prefixes sit at the lowest addresses, and a first-match priority search of the table returns the longest match. Each accepted insert request carries a prefix and a length. The block writes a data word (the prefix with its host bits cleared) and a mask word (ones over the compared bits) into an external entry store through a single read/write port.

When the target segment has a spare slot, the new entry goes straight into it. When the target is full, the block finds the nearest segment that still has room. It then moves one boundary entry of every non-empty segment in between, so that a free slot travels to the target. Segment boundaries are updated after each move. For the whole update, `busy` tells the search side to stall. When the update finishes, a one-cycle `done` reports how many relocations were needed, or that the table was already full.

Top module: `lpm_seg_updater`

## Requirements
- R1: Across any series of inserts, the mask words read in ascending address order never increase in their number of ones. Longer prefixes therefore always lie at lower addresses.
- R2: After reset, segment s starts at address floor(s*DEPTH/33) and holds no entries. With the default DEPTH of 66, each segment owns two slots at 2s and 2s+1. A request whose target segment has room is written at the segment start plus its current entry count, with no relocation.
- R3: The data word stored for a request is the prefix ANDed with the mask. The mask word has `len` leading ones (bit 31 downward) and zeros below. Length 0 gives an all-zero mask.
- R4: If the target segment is full, the nearest higher-index segment with room is used first. Each non-empty segment from that one down to the one just above the target moves its lowest-addressed entry to the slot just past its last entry, and its start grows by one. The new entry is written just past the target's last entry.
- R5: If no higher-index segment has room, the nearest lower-index segment with room is used. Each non-empty segment strictly between it and the target moves its highest-addressed entry to the slot just below its start, and its start drops by one. The new entry is written at the slot just below the target's old start.
- R6: One relocation uses exactly four storage cycles in this order: read data word, write data word, read mask word, write mask word. The source is the same for both reads and the destination is the same for both writes. `memSel` is 0 for the data word and 1 for the mask word. Read data returns on `memRdata` in the cycle after the read. Each insert ends with two write cycles: data, then mask.
- R7: `moveCount` gives the number of relocations made for the request. An empty segment on the path only shifts its boundary and adds nothing to the count.
- R8: `busy` rises in the cycle after a request is accepted and stays high up to and including the last write. Every storage access happens while `busy` is high. `done` is a one-cycle pulse in the cycle after the last write, and `busy` is low in that cycle.
- R9: While `busy` is high, `reqReady` is low. A request presented then is ignored and causes no later storage access.
- R10: If no segment has a free slot, the request ends with `done` and `err` both high, `moveCount` equal to 0 and no storage access. `err` stays high until the next accepted request.
- R11: After reset, `busy`, `done` and `err` are low and `reqReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Insert request present |
| reqReady | output | 1 | Block can accept a request |
| reqPrefix | input | 32 | Prefix to insert |
| reqLen | input | 6 | Prefix length, 0 to 32 (larger values treated as 32) |
| busy | output | 1 | Update in progress; lookups must stall |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request found the table full |
| moveCount | output | 6 | Relocations made for the last request |
| memReq | output | 1 | Storage access this cycle |
| memWe | output | 1 | Access is a write |
| memSel | output | 1 | 0 selects the data word, 1 the mask word |
| memAddr | output | 7 | Entry address |
| memWdata | output | 32 | Word to write |
| memRdata | input | 32 | Word read, valid the cycle after a read |

## Verification
A corrupted segment start or entry count shows up at the ports on the next insert that lands in or walks through that segment. The write address is off by the error, or an entry is copied over a live slot, and the mask-order scan of the modelled store catches this as soon as the request finishes. A wrong walk direction or a skipped empty segment changes `moveCount` and the logged sequence of storage addresses for that same request. Each directed scenario therefore compares the exact address sequence and the final store contents against values worked out by hand from the starting layout.

// File: rtl/lpm_upd_pkg.sv
package lpm_upd_pkg;
  localparam int KEY_W = 32;
  localparam int NSEG  = KEY_W + 1;
  localparam int SEG_W = $clog2(NSEG);
  localparam int LEN_W = $clog2(KEY_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_PLAN, ST_STEP, ST_RD_D, ST_WR_D, ST_RD_M, ST_WR_M, ST_INS_D, ST_INS_M
  } updState_t;

  typedef enum logic [1:0] { AD_FROM, AD_TO, AD_INS } addrSel_t;

  typedef struct packed {
    logic     latch;
    logic     plan;
    logic     memReq;
    logic     memWe;
    logic     memSel;
    addrSel_t addrSel;
    logic     shift;
    logic     commit;
    logic     countMove;
  } updStrobe_t;
endpackage

// File: rtl/lpm_upd_ctrl.sv
module lpm_upd_ctrl
  import lpm_upd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       tgtFree,
  input  logic       anyFree,
  input  logic       kAtTgt,
  input  logic       kEmpty,
  output updStrobe_t strobe,
  output logic       busy,
  output logic       done
);
  updState_t state, stateNext;
  logic doneNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    doneNext  = 1'b0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        strobe.latch = 1'b1;
        stateNext    = ST_PLAN;
      end
      ST_PLAN: begin
        strobe.plan = 1'b1;
        if (!anyFree) begin
          doneNext  = 1'b1;
          stateNext = ST_IDLE;
        end else if (tgtFree) stateNext = ST_INS_D;
        else                  stateNext = ST_STEP;
      end
      ST_STEP: begin
        if (kAtTgt)      stateNext = ST_INS_D;
        else if (kEmpty) strobe.shift = 1'b1;
        else             stateNext = ST_RD_D;
      end
      ST_RD_D: begin
        strobe.memReq = 1'b1; strobe.addrSel = AD_FROM;
        stateNext = ST_WR_D;
      end
      ST_WR_D: begin
        strobe.memReq = 1'b1; strobe.memWe = 1'b1; strobe.addrSel = AD_TO;
        stateNext = ST_RD_M;
      end
      ST_RD_M: begin
        strobe.memReq = 1'b1; strobe.memSel = 1'b1; strobe.addrSel = AD_FROM;
        stateNext = ST_WR_M;
      end
      ST_WR_M: begin
        strobe.memReq = 1'b1; strobe.memWe = 1'b1; strobe.memSel = 1'b1;
        strobe.addrSel = AD_TO; strobe.shift = 1'b1; strobe.countMove = 1'b1;
        stateNext = ST_STEP;
      end
      ST_INS_D: begin
        strobe.memReq = 1'b1; strobe.memWe = 1'b1; strobe.addrSel = AD_INS;
        stateNext = ST_INS_M;
      end
      ST_INS_M: begin
        strobe.memReq = 1'b1; strobe.memWe = 1'b1; strobe.memSel = 1'b1;
        strobe.addrSel = AD_INS; strobe.commit = 1'b1;
        doneNext  = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= doneNext;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/lpm_upd_path.sv
module lpm_upd_path
  import lpm_upd_pkg::*;
#(
  parameter int DEPTH  = 66,
  parameter int ADDR_W = 7,
  parameter int IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  updStrobe_t        strobe,
  input  logic [KEY_W-1:0]  reqPrefix,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [KEY_W-1:0]  memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [KEY_W-1:0]  memWdata,
  output logic              tgtFree,
  output logic              anyFree,
  output logic              kAtTgt,
  output logic              kEmpty,
  output logic              err,
  output logic [SEG_W-1:0]  moveCount
);
  logic [IDX_W-1:0] segStart [NSEG];
  logic [IDX_W-1:0] segUsed  [NSEG];
  logic [IDX_W-1:0] segEnd   [NSEG];
  logic [IDX_W-1:0] segLimit [NSEG];
  logic [NSEG-1:0]  segFree;

  logic [SEG_W-1:0] tgtSeg, kSeg, upIdx, dnIdx;
  logic             upFound, dnFound, dirDown;
  logic [KEY_W-1:0] keyQ, maskQ;
  logic [LEN_W-1:0] lenSat;

  function automatic logic [KEY_W-1:0] lenMask(input logic [LEN_W-1:0] l);
    return ~({KEY_W{1'b1}} >> l);
  endfunction

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    assign segEnd[s] = segStart[s] + segUsed[s];
    if (s == NSEG - 1) begin : g_last
      assign segLimit[s] = IDX_W'(DEPTH);
    end else begin : g_mid
      assign segLimit[s] = segStart[s+1];
    end
    assign segFree[s] = segEnd[s] < segLimit[s];
  end

  // nearest segment with room on each side of the target
  always_comb begin
    upFound = 1'b0; upIdx = '0;
    for (int s = NSEG - 1; s >= 0; s--) begin
      if (segFree[s] && (SEG_W'(s) > tgtSeg)) begin
        upFound = 1'b1; upIdx = SEG_W'(s);
      end
    end
    dnFound = 1'b0; dnIdx = '0;
    for (int s = 0; s < NSEG; s++) begin
      if (segFree[s] && (SEG_W'(s) < tgtSeg)) begin
        dnFound = 1'b1; dnIdx = SEG_W'(s);
      end
    end
  end

  assign tgtFree = segFree[tgtSeg];
  assign anyFree = tgtFree | upFound | dnFound;
  assign kAtTgt  = (kSeg == tgtSeg);
  assign kEmpty  = (segUsed[kSeg] == '0);
  assign lenSat  = (reqLen > LEN_W'(KEY_W)) ? LEN_W'(KEY_W) : reqLen;

  logic [IDX_W-1:0] curStart, curUsed, fromIdx, toIdx, insIdx, addrIdx;
  assign curStart = segStart[kSeg];
  assign curUsed  = segUsed[kSeg];
  assign fromIdx  = dirDown ? (curStart + curUsed - IDX_W'(1)) : curStart;
  assign toIdx    = dirDown ? (curStart - IDX_W'(1)) : (curStart + curUsed);
  assign insIdx   = dirDown ? (segStart[tgtSeg] - IDX_W'(1))
                            : (segStart[tgtSeg] + segUsed[tgtSeg]);

  always_comb begin
    unique case (strobe.addrSel)
      AD_FROM: addrIdx = fromIdx;
      AD_TO:   addrIdx = toIdx;
      default: addrIdx = insIdx;
    endcase
  end

  assign memAddr  = ADDR_W'(addrIdx);
  assign memWdata = (strobe.addrSel == AD_INS) ? (strobe.memSel ? maskQ : keyQ) : memRdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NSEG; s++) begin
        segStart[s] <= IDX_W'((s * DEPTH) / NSEG);
        segUsed[s]  <= '0;
      end
      tgtSeg    <= '0;
      kSeg      <= '0;
      dirDown   <= 1'b0;
      keyQ      <= '0;
      maskQ     <= '0;
      err       <= 1'b0;
      moveCount <= '0;
    end else begin
      if (strobe.latch) begin
        tgtSeg    <= SEG_W'(KEY_W) - SEG_W'(lenSat);
        maskQ     <= lenMask(lenSat);
        keyQ      <= reqPrefix & lenMask(lenSat);
        err       <= 1'b0;
        moveCount <= '0;
      end
      if (strobe.plan) begin
        dirDown <= !tgtFree && !upFound;
        if (tgtFree)      kSeg <= tgtSeg;
        else if (upFound) kSeg <= upIdx;
        else              kSeg <= dnIdx + SEG_W'(1);
        if (!anyFree) err <= 1'b1;
      end
      if (strobe.shift) begin
        if (dirDown) begin
          segStart[kSeg] <= curStart - IDX_W'(1);
          kSeg           <= kSeg + SEG_W'(1);
        end else begin
          segStart[kSeg] <= curStart + IDX_W'(1);
          kSeg           <= kSeg - SEG_W'(1);
        end
      end
      if (strobe.countMove) moveCount <= moveCount + SEG_W'(1);
      if (strobe.commit) begin
        segUsed[tgtSeg] <= segUsed[tgtSeg] + IDX_W'(1);
        if (dirDown) segStart[tgtSeg] <= segStart[tgtSeg] - IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/lpm_seg_updater.sv
module lpm_seg_updater
  import lpm_upd_pkg::*;
#(
  parameter int DEPTH  = 66,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int IDX_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [KEY_W-1:0]  reqPrefix,
  input  logic [LEN_W-1:0]  reqLen,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [SEG_W-1:0]  moveCount,
  output logic              memReq,
  output logic              memWe,
  output logic              memSel,
  output logic [ADDR_W-1:0] memAddr,
  output logic [KEY_W-1:0]  memWdata,
  input  logic [KEY_W-1:0]  memRdata
);
  updStrobe_t strobe;
  logic tgtFree, anyFree, kAtTgt, kEmpty;

  lpm_upd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .tgtFree(tgtFree), .anyFree(anyFree), .kAtTgt(kAtTgt), .kEmpty(kEmpty),
    .strobe(strobe), .busy(busy), .done(done)
  );

  lpm_upd_path #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqPrefix(reqPrefix), .reqLen(reqLen), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata),
    .tgtFree(tgtFree), .anyFree(anyFree), .kAtTgt(kAtTgt), .kEmpty(kEmpty),
    .err(err), .moveCount(moveCount)
  );

  assign reqReady = !busy;
  assign memReq   = strobe.memReq;
  assign memWe    = strobe.memWe;
  assign memSel   = strobe.memSel;
endmodule

// File: rtl/lpm_upd_checker.sv
module lpm_upd_checker #(
  parameter int DEPTH  = 66,
  parameter int ADDR_W = 7,
  parameter int SEG_W  = 6,
  parameter int NSEG   = 33
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [SEG_W-1:0]  moveCount,
  input logic              memReq,
  input logic              memWe,
  input logic              memSel,
  input logic [ADDR_W-1:0] memAddr
);
  a_r8_access_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);
  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> busy);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  a_r9_busy_needs_request: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid));
  a_r6_read_then_write: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe) |=> (memReq && memWe && (memSel == $past(memSel))));
  a_r10_full_no_moves: assert property (@(posedge clk) disable iff (!rstN)
    (done && err) |-> (moveCount == '0));
  a_r2_addr_in_range: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (int'(memAddr) < DEPTH));
  a_r7_moves_bounded: assert property (@(posedge clk) disable iff (!rstN)
    int'(moveCount) < NSEG);
endmodule

bind lpm_seg_updater lpm_upd_checker #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .SEG_W(lpm_upd_pkg::SEG_W), .NSEG(lpm_upd_pkg::NSEG)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .busy(busy), .done(done), .err(err), .moveCount(moveCount),
  .memReq(memReq), .memWe(memWe), .memSel(memSel), .memAddr(memAddr)
);

// File: tb/test_lpm_seg_updater.sv
module test_lpm_seg_updater;
  localparam int DEPTH = 66;
  localparam int AW    = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [31:0] reqPrefix = '0;
  logic [5:0]  reqLen = '0;
  logic reqReady, busy, done, err, memReq, memWe, memSel;
  logic [5:0]  moveCount;
  logic [AW-1:0] memAddr;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;

  lpm_seg_updater #(.DEPTH(DEPTH)) i_lpm_seg_updater (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqPrefix(reqPrefix), .reqLen(reqLen), .busy(busy), .done(done), .err(err),
    .moveCount(moveCount), .memReq(memReq), .memWe(memWe), .memSel(memSel),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata)
  );

  always #2.5 clk = ~clk;

  logic [31:0] dataMem [DEPTH];
  logic [31:0] maskMem [DEPTH];
  logic        usedMem [DEPTH];
  int opCount = 0;
  int idleAccess = 0;
  logic        logWe   [256];
  logic        logSel  [256];
  int          logAddr [256];
  logic        clearMem = 1'b0;

  always @(posedge clk) begin
    if (clearMem) begin
      for (int a = 0; a < DEPTH; a++) begin
        dataMem[a] <= 'x; maskMem[a] <= 'x; usedMem[a] <= 1'b0;
      end
    end else if (memReq) begin
      if (memWe) begin
        if (memSel) maskMem[memAddr] <= memWdata;
        else        dataMem[memAddr] <= memWdata;
        usedMem[memAddr] <= 1'b1;
      end else begin
        memRdata <= memSel ? maskMem[memAddr] : dataMem[memAddr];
      end
      logWe[opCount % 256]   <= memWe;
      logSel[opCount % 256]  <= memSel;
      logAddr[opCount % 256] <= int'(memAddr);
      opCount <= opCount + 1;
      if (!busy) idleAccess <= idleAccess + 1;
    end
  end

  int testsRun = 0;
  int testsFail = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] maskOf(input int l);
    return (l == 0) ? 32'h0 : (32'hFFFF_FFFF << (32 - l));
  endfunction

  task automatic resetDut();
    @(negedge clk);
    rstN = 1'b0; clearMem = 1'b1; reqValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1; clearMem = 1'b0;
    @(negedge clk);
  endtask

  // one insert; returns moves, err flag, storage cycles and the first op index
  task automatic doInsert(input logic [31:0] p, input int l, output int mv,
                          output bit e, output int ops, output int op0);
    @(negedge clk);
    reqValid = 1'b1; reqPrefix = p; reqLen = 6'(l);
    op0 = opCount;
    @(negedge clk);
    reqValid = 1'b0;
    if (!busy) begin testsRun++; testsFail++; $display("FAIL R8 busy=0 expected=1 after accept"); end
    while (!done) @(negedge clk);
    mv = int'(moveCount); e = err; ops = opCount - op0;
    if (busy) begin testsRun++; testsFail++; $display("FAIL R8 busy=1 expected=0 with done"); end
  endtask

  task automatic checkEntry(input int a, input logic [31:0] p, input int l, input string tag);
    check(dataMem[a] === (p & maskOf(l)), {tag, " data"}, dataMem[a], p & maskOf(l));
    check(maskMem[a] === maskOf(l), {tag, " mask"}, maskMem[a], maskOf(l));
  endtask

  task automatic checkOp(input int idx, input bit we, input bit sel, input int a, input string tag);
    int i;
    i = idx % 256;
    check(logWe[i] == we && logSel[i] == sel && logAddr[i] == a, tag,
          {logWe[i], logSel[i], 8'(logAddr[i])}, {we, sel, 8'(a)});
  endtask

  task automatic testReset();
    check(busy == 0 && done == 0 && err == 0, "R11 reset outputs", {busy, done, err}, 0);
    check(reqReady == 1, "R11 ready after reset", reqReady, 1);
  endtask

  task automatic testDirectAndUpward();
    int mv, ops, op0; bit e;
    doInsert(32'hC0A8_0117, 24, mv, e, ops, op0);
    check(mv == 0 && ops == 2, "R2 direct insert moves/ops", {mv, ops}, {32'd0, 32'd2});
    checkOp(op0, 1, 0, 16, "R2 direct data address");
    checkOp(op0 + 1, 1, 1, 16, "R6 insert mask write follows data");
    checkEntry(16, 32'hC0A8_0117, 24, "R3 first entry");
    doInsert(32'h0A00_0001, 24, mv, e, ops, op0);
    checkOp(op0, 1, 0, 17, "R2 second slot address");
    doInsert(32'h0B00_0001, 24, mv, e, ops, op0);
    check(mv == 0, "R7 empty neighbour adds no move", mv, 0);
    checkOp(op0, 1, 0, 18, "R4 slot borrowed from empty segment");
    doInsert(32'h1234_5678, 23, mv, e, ops, op0);
    checkOp(op0, 1, 0, 19, "R4 len23 first");
    doInsert(32'h2234_5678, 23, mv, e, ops, op0);
    checkOp(op0, 1, 0, 20, "R4 len23 second");
    doInsert(32'h0C00_0001, 24, mv, e, ops, op0);
    check(mv == 1 && ops == 6, "R6 one move costs four cycles", {mv, ops}, {32'd1, 32'd6});
    checkOp(op0,     0, 0, 19, "R6 move read data");
    checkOp(op0 + 1, 1, 0, 21, "R6 move write data");
    checkOp(op0 + 2, 0, 1, 19, "R6 move read mask");
    checkOp(op0 + 3, 1, 1, 21, "R6 move write mask");
    checkEntry(21, 32'h1234_5678, 23, "R4 relocated entry");
    checkEntry(19, 32'h0C00_0001, 24, "R4 new entry at target end");
  endtask

  task automatic testDownward();
    int mv, ops, op0; bit e;
    doInsert(32'h1111_1111, 0, mv, e, ops, op0);
    doInsert(32'h2222_2222, 0, mv, e, ops, op0);
    doInsert(32'hFFFF_FFFF, 1, mv, e, ops, op0);
    checkOp(op0, 1, 0, 62, "R2 len1 slot");
    doInsert(32'h3333_3333, 0, mv, e, ops, op0);
    check(mv == 0, "R5 borrow from lower neighbour", mv, 0);
    checkOp(op0, 1, 0, 63, "R5 slot below target start");
    doInsert(32'h7FFF_FFFF, 1, mv, e, ops, op0);
    checkOp(op0, 1, 0, 61, "R5 len1 below its start");
    doInsert(32'h4444_4444, 0, mv, e, ops, op0);
    check(mv == 1, "R5 one downward move", mv, 1);
    checkOp(op0,     0, 0, 62, "R5 read last entry");
    checkOp(op0 + 1, 1, 0, 60, "R5 write below start");
    checkEntry(60, 32'hFFFF_FFFF, 1, "R5 relocated len1");
    checkEntry(61, 32'h7FFF_FFFF, 1, "R5 untouched len1");
    checkEntry(62, 32'h4444_4444, 0, "R3 len0 all-zero words");
  endtask

  task automatic testChain();
    int mv, ops, op0; bit e;
    resetDut();
    for (int s = 0; s < 4; s++) begin
      for (int n = 0; n < 2; n++) doInsert(32'hA000_0000 + 32'(s * 16 + n), 32 - s, mv, e, ops, op0);
    end
    doInsert(32'hBEEF_0001, 32, mv, e, ops, op0);
    check(mv == 3 && ops == 14, "R7 three-move chain", {mv, ops}, {32'd3, 32'd14});
    checkOp(op0,     0, 0, 6, "R4 chain first source");
    checkOp(op0 + 1, 1, 0, 8, "R4 chain first dest");
    checkOp(op0 + 4, 0, 0, 4, "R4 chain second source");
    checkOp(op0 + 9, 1, 0, 4, "R4 chain third dest");
    checkOp(op0 + 12, 1, 0, 2, "R4 chain insert address");
    checkEntry(8, 32'hA000_0030, 29, "R4 len29 moved");
    checkEntry(4, 32'hA000_0010, 31, "R4 len31 moved");
  endtask

  task automatic testRefused();
    int op0, opEnd; bit sawReady;
    sawReady = 0;
    @(negedge clk);
    reqValid = 1'b1; reqPrefix = 32'h5555_0000; reqLen = 6'd31;
    op0 = opCount;
    @(negedge clk);
    reqPrefix = 32'h0808_0808; reqLen = 6'd8;
    for (int c = 0; c < 3; c++) begin
      if (reqReady) sawReady = 1;
      @(negedge clk);
    end
    reqValid = 1'b0;
    while (!done) @(negedge clk);
    check(!sawReady, "R9 ready low while busy", sawReady, 0);
    check(moveCount == 2, "R9 accepted request moves", moveCount, 2);
    opEnd = opCount;
    repeat (6) @(negedge clk);
    check(opCount == opEnd && !busy, "R9 refused request left no trace", opCount - opEnd, 0);
    check(idleAccess == 0, "R8 no access while idle", idleAccess, 0);
  endtask

  task automatic testFill();
    int mv, ops, op0, bad, prevOnes, ones; bit e;
    resetDut();
    for (int i = 0; i < DEPTH; i++) begin
      doInsert(32'h0102_0305 * 32'(i + 1), (i * 7) % 33, mv, e, ops, op0);
      if (e) bad++;
    end
    check(bad == 0, "R10 no error before full", bad, 0);
    bad = 0; prevOnes = 33;
    for (int a = 0; a < DEPTH; a++) begin
      ones = $countones(maskMem[a]);
      if (!usedMem[a] || ones > prevOnes || (dataMem[a] & ~maskMem[a]) != 0) bad++;
      prevOnes = ones;
    end
    check(bad == 0, "R1 mask lengths non-increasing", bad, 0);
    doInsert(32'hDEAD_BEEF, 12, mv, e, ops, op0);
    check(e && mv == 0 && ops == 0, "R10 full table error", {e, 8'(mv), 8'(ops)}, {1'b1, 16'd0});
    repeat (3) @(negedge clk);
    check(err == 1, "R10 err held", err, 1);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    testsRun++; testsFail++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    resetDut();
    testReset();
    testDirectAndUpward();
    testDownward();
    testChain();
    testRefused();
    testFill();
    resetDut();
    testReset();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end
endmodule